// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Controller

This block produces the frequency-offset word that steers a fractional-N synthesizer or a digitally controlled oscillator, so that the generated clock sweeps its frequency in a triangle and its spectral energy is spread out. A two-bit select chooses both the sweep direction and the depth. With center spread the offset swings evenly above and below nominal. With down spread it only ever moves below nominal, so the clock never runs faster than the unspread clock. An enable input turns the sweep off. While the sweep is off, the offset is exactly zero.

The offset is a signed integer in parts per million of the nominal frequency. Internally it comes from a fixed-point accumulator that snaps to exact values at the turning points and at the zero points. Because the triangle period is counted in reference cycles, the sweep rate follows the reference frequency while the depth in ppm stays fixed. A new select or enable value is taken only when the offset sits at zero, so a mode change never makes the frequency jump. The enable input is expected to carry a pull-up at the pad, so that the sweep is on when the pin is left open. That pull-up lies outside this block.

Top module: `spread_tri_mod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `offset_o` is 0 and `down_mode_o` is 0.
- R2: The select codes, with bit 1 choosing the direction (0 = center, 1 = down), set these peaks: 00 gives ±15000 ppm, 01 gives ±5000 ppm, 10 gives 0 to −10000 ppm and 11 gives 0 to −30000 ppm. The sweep reaches these extremes exactly and never passes them.
- R3: While the active enable is 0, `offset_o` is exactly 0 and `down_mode_o` is 0, whatever the select input does.
- R4: In center mode with half-period N = `HALF_CYC`, the offset at phase c of the 2N-cycle period is a triangle: it falls linearly from 0 to −A at c = N/2, rises to +A at c = 3N/2, and returns to 0 at c = 2N. The slope is 2A/N ppm per cycle.
- R5: In down mode the offset falls linearly from 0 to −D at c = N and rises back to 0 at c = 2N, with a slope of D/N ppm per cycle. It is never positive.
- R6: On the first cycle after a new enabled configuration takes effect, the offset is minus one slope step, so every sweep starts downward.
- R7: A change of select or enable is adopted only at a zero point of the running sweep: phase 0 in either mode, phase N in center mode, or any cycle while disabled. At other times the old configuration continues.
- R8: `down_mode_o` is 1 exactly when the active configuration is enabled with select bit 1 set.
- R9: Two consecutive offsets never differ by more than one slope step of the deepest mode (the largest step plus one for rounding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_sel_i | input | 2 | Direction and depth select |
| spread_en_i | input | 1 | Sweep enable (1 = on) |
| offset_o | output | OFS_W (17) | Registered signed frequency offset in ppm |
| down_mode_o | output | 1 | Active configuration is down spread |

## Verification
Each of the four select codes is swept through two full periods from reset, so the per-cycle slope, the turning points and the peak values for each code can be compared against the triangle formula. The enable is dropped in the middle of a ramp to show that the sweep finishes its leg before going quiet and that select toggling while disabled has no effect. A select change made in the middle of a ramp separates adoption at a zero point from immediate adoption. A long pseudo-random run of enable and select changes then compares every cycle against an arithmetic model of phase and configuration, and so exercises restarts at both the start-of-period and mid-period zero points.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
   typedef struct packed {
      logic       en;
      logic [1:0] sel;
   } spread_cfg_t;

   function automatic logic cfg_is_down(input spread_cfg_t c);
      return c.sel[1];
   endfunction
endpackage

// File: rtl/ssc_cfg_gate.sv
`timescale 1ns/1ps
module ssc_cfg_gate
   import ssc_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        zero_pt_i,
   input  logic        en_i,
   input  logic [1:0]  sel_i,
   output spread_cfg_t cfg_q_o,
   output spread_cfg_t cfg_use_o,
   output logic        take_o
);
   spread_cfg_t req;
   spread_cfg_t cfg_q;

   assign req       = {en_i, sel_i};
   assign take_o    = zero_pt_i && (req != cfg_q);
   assign cfg_use_o = take_o ? req : cfg_q;
   assign cfg_q_o   = cfg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q <= '0;
      else if (take_o) cfg_q <= req;
   end
endmodule

// File: rtl/ssc_phase.sv
`timescale 1ns/1ps
module ssc_phase #(
   parameter int HALF_CYC = 8,
   parameter int CNT_W    = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             act_en_i,
   input  logic             act_down_i,
   input  logic             use_en_i,
   input  logic             take_i,
   output logic             zero_pt_o,
   output logic [CNT_W-1:0] cnt_nx_o
);
   localparam logic [CNT_W-1:0] P_HALF = CNT_W'(HALF_CYC);
   localparam logic [CNT_W-1:0] P_LAST = CNT_W'(2 * HALF_CYC - 1);
   localparam logic [CNT_W-1:0] P_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur;

   assign zero_pt_o = !act_en_i || (cnt_q == '0) || (!act_down_i && cnt_q == P_HALF);

   always_comb begin
      cur = take_i ? '0 : cnt_q;
      if (!use_en_i)          cnt_nx_o = '0;
      else if (cur == P_LAST) cnt_nx_o = '0;
      else                    cnt_nx_o = cur + P_ONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_nx_o;
   end
endmodule

// File: rtl/ssc_ramp.sv
`timescale 1ns/1ps
module ssc_ramp
   import ssc_pkg::*;
#(
   parameter int HALF_CYC        = 8,
   parameter int CNT_W           = 4,
   parameter int OFS_W           = 17,
   parameter int FRAC_W          = 8,
   parameter int DEPTH_C_WIDE    = 15000,
   parameter int DEPTH_C_NARROW  = 5000,
   parameter int DEPTH_D_SHALLOW = 10000,
   parameter int DEPTH_D_DEEP    = 30000,
   parameter bit ROUND_NEAR      = 1'b0
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  spread_cfg_t             cfg_use_i,
   input  logic                    take_i,
   input  logic [CNT_W-1:0]        cnt_nx_i,
   output logic signed [OFS_W-1:0] ofs_o
);
   localparam int ACC_W = OFS_W + FRAC_W;
   localparam int FX    = 1 << FRAC_W;
   localparam logic [CNT_W-1:0] P_QTR  = CNT_W'(HALF_CYC / 2);
   localparam logic [CNT_W-1:0] P_HALF = CNT_W'(HALF_CYC);
   localparam logic [CNT_W-1:0] P_3QTR = CNT_W'(3 * HALF_CYC / 2);

   logic signed [ACC_W-1:0] amp_tab  [4];
   logic signed [ACC_W-1:0] step_tab [4];

   for (genvar g = 0; g < 4; g++) begin : g_mode
      localparam int DEP  = (g == 0) ? DEPTH_C_WIDE : (g == 1) ? DEPTH_C_NARROW :
                            (g == 2) ? DEPTH_D_SHALLOW : DEPTH_D_DEEP;
      localparam int SPAN = (g < 2) ? 2 * DEP : DEP;
      assign amp_tab[g]  = ACC_W'(DEP * FX);
      assign step_tab[g] = ACC_W'((SPAN * FX) / HALF_CYC);
   end

   logic signed [ACC_W-1:0] acc_q, acc_nx, acc_cur, amp, step;
   logic is_down, falling;

   always_comb begin
      amp     = amp_tab[cfg_use_i.sel];
      step    = step_tab[cfg_use_i.sel];
      is_down = cfg_is_down(cfg_use_i);
      acc_cur = take_i ? '0 : acc_q;
      falling = is_down ? (cnt_nx_i < P_HALF) : ((cnt_nx_i < P_QTR) || (cnt_nx_i > P_3QTR));
      if (!cfg_use_i.en)                               acc_nx = '0;
      else if (cnt_nx_i == '0)                         acc_nx = '0;
      else if (!is_down && cnt_nx_i == P_HALF)         acc_nx = '0;
      else if (!is_down && cnt_nx_i == P_QTR)          acc_nx = -amp;
      else if (!is_down && cnt_nx_i == P_3QTR)         acc_nx = amp;
      else if (is_down && cnt_nx_i == P_HALF)          acc_nx = -amp;
      else if (falling)                                acc_nx = acc_cur - step;
      else                                             acc_nx = acc_cur + step;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else         acc_q <= acc_nx;
   end

   if (ROUND_NEAR) begin : g_near
      localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (FRAC_W - 1));
      logic signed [ACC_W-1:0] biased;
      assign biased = acc_q + HALF_LSB;
      assign ofs_o  = OFS_W'(biased >>> FRAC_W);
   end else begin : g_floor
      assign ofs_o  = OFS_W'(acc_q >>> FRAC_W);
   end
endmodule

// File: rtl/spread_tri_mod.sv
`timescale 1ns/1ps
module spread_tri_mod
   import ssc_pkg::*;
#(
   parameter int HALF_CYC        = 8,
   parameter int OFS_W           = 17,
   parameter int FRAC_W          = 8,
   parameter int DEPTH_C_WIDE    = 15000,
   parameter int DEPTH_C_NARROW  = 5000,
   parameter int DEPTH_D_SHALLOW = 10000,
   parameter int DEPTH_D_DEEP    = 30000,
   parameter bit ROUND_NEAR      = 1'b0
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [1:0]              spread_sel_i,
   input  logic                    spread_en_i,
   output logic signed [OFS_W-1:0] offset_o,
   output logic                    down_mode_o
);
   localparam int CNT_W   = $clog2(2 * HALF_CYC);
   localparam int C_MAX   = (DEPTH_C_WIDE > DEPTH_C_NARROW) ? DEPTH_C_WIDE : DEPTH_C_NARROW;
   localparam int D_MAX   = (DEPTH_D_SHALLOW > DEPTH_D_DEEP) ? DEPTH_D_SHALLOW : DEPTH_D_DEEP;
   localparam int SL_C    = (2 * C_MAX + HALF_CYC - 1) / HALF_CYC;
   localparam int SL_D    = (D_MAX + HALF_CYC - 1) / HALF_CYC;
   localparam int MAX_STEP = ((SL_C > SL_D) ? SL_C : SL_D) + 1;
   localparam int PEAK    = (C_MAX > D_MAX) ? C_MAX : D_MAX;

   if (HALF_CYC < 2 || (HALF_CYC % 2) != 0) begin : g_chk_half
      $error("HALF_CYC must be even and at least 2");
   end
   if (PEAK >= (1 << (OFS_W - 1))) begin : g_chk_ofs
      $error("OFS_W too narrow for the largest depth");
   end
   if (FRAC_W < 1 || (2 * C_MAX) >= ((1 << (30 - FRAC_W)))) begin : g_chk_frac
      $error("FRAC_W out of range for the depth parameters");
   end

   spread_cfg_t      cfg_q, cfg_use;
   logic             take, zero_pt;
   logic [CNT_W-1:0] cnt_nx;

   ssc_cfg_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .zero_pt_i (zero_pt),
      .en_i      (spread_en_i),
      .sel_i     (spread_sel_i),
      .cfg_q_o   (cfg_q),
      .cfg_use_o (cfg_use),
      .take_o    (take)
   );

   ssc_phase #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_en_i   (cfg_q.en),
      .act_down_i (cfg_q.sel[1]),
      .use_en_i   (cfg_use.en),
      .take_i     (take),
      .zero_pt_o  (zero_pt),
      .cnt_nx_o   (cnt_nx)
   );

   ssc_ramp #(
      .HALF_CYC(HALF_CYC), .CNT_W(CNT_W), .OFS_W(OFS_W), .FRAC_W(FRAC_W),
      .DEPTH_C_WIDE(DEPTH_C_WIDE), .DEPTH_C_NARROW(DEPTH_C_NARROW),
      .DEPTH_D_SHALLOW(DEPTH_D_SHALLOW), .DEPTH_D_DEEP(DEPTH_D_DEEP),
      .ROUND_NEAR(ROUND_NEAR)
   ) u_ramp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_use_i (cfg_use),
      .take_i    (take),
      .cnt_nx_i  (cnt_nx),
      .ofs_o     (offset_o)
   );

   assign down_mode_o = cfg_q.en & cfg_q.sel[1];

   AST_DOWN_NONPOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.en && cfg_q.sel[1]) |-> (int'(offset_o) <= 0)); // R5
   AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_q.en |-> (offset_o == '0)); // R3
   AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.en && !cfg_q.sel[1]) |->
      ((int'(offset_o) <= (cfg_q.sel[0] ? DEPTH_C_NARROW : DEPTH_C_WIDE)) &&
       (int'(offset_o) >= -(cfg_q.sel[0] ? DEPTH_C_NARROW : DEPTH_C_WIDE)))); // R2
   AST_NO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((int'(offset_o) - int'($past(offset_o)) <= MAX_STEP) &&
       (int'($past(offset_o)) - int'(offset_o) <= MAX_STEP))); // R9
   AST_CFG_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_q) |-> ($past(offset_o) == '0)); // R7
   AST_START_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(cfg_q) && cfg_q.en) |-> (int'(offset_o) < 0)); // R6
endmodule

// File: tb/spread_tri_mod_test.sv
`timescale 1ns/1ps
module spread_tri_mod_test;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] sel = 2'd0;
   logic en = 1'b1;
   logic signed [16:0] ofs;
   logic dmode;

   always #5 clk = ~clk;

   spread_tri_mod uut (
      .clk_i(clk), .rst_ni(rst_n), .spread_sel_i(sel), .spread_en_i(en),
      .offset_o(ofs), .down_mode_o(dmode)
   );

   int checks = 0, errors = 0;
   int m_en = 0, m_sel = 0, m_c = 0, prev_ofs = 0;
   int lo_seen, hi_seen;
   bit done = 1'b0;

   function automatic int depth_of(int s);
      case (s)
         0: return 15000;
         1: return 5000;
         2: return 10000;
         default: return 30000;
      endcase
   endfunction

   function automatic int slope_of(int s);
      return (s < 2) ? (2 * depth_of(s)) / N : depth_of(s) / N;
   endfunction

   function automatic int tri_at(int s, int c);
      int a, sl, q;
      a = depth_of(s); sl = slope_of(s); q = N / 2;
      if (s < 2) begin
         if (c <= q)          return -sl * c;
         else if (c <= 3 * q) return -a + sl * (c - q);
         else                 return a - sl * (c - 3 * q);
      end else begin
         if (c <= N) return -sl * c;
         else        return -a + sl * (c - N);
      end
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_en = 0; m_sel = 0; m_c = 0; prev_ofs = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic tick();
      bit zero;
      @(posedge clk);
      zero = (m_en == 0) || (m_c == 0) || (m_sel < 2 && m_c == N);
      if (zero && (int'(en) != m_en || int'(sel) != m_sel)) begin
         m_en = int'(en); m_sel = int'(sel); m_c = en ? 1 : 0;
      end else if (m_en != 0) begin
         m_c = (m_c + 1) % (2 * N);
      end
      #2;
   endtask

   task automatic run(int cycles, string tag);
      int e, d;
      for (int k = 0; k < cycles; k++) begin
         tick();
         e = (m_en != 0) ? tri_at(m_sel, m_c) : 0;
         chk(tag, int'(ofs), e);
         chk("R8", int'(dmode), (m_en != 0 && m_sel >= 2) ? 1 : 0);
         d = int'(ofs) - prev_ofs;
         if (d < 0) d = -d;
         chk("R9", (d <= 3751) ? 1 : 0, 1);
         prev_ofs = int'(ofs);
         if (int'(ofs) < lo_seen) lo_seen = int'(ofs);
         if (int'(ofs) > hi_seen) hi_seen = int'(ofs);
      end
   endtask

   initial begin
      int lfsr;
      rst_n = 1'b0;
      #12;
      chk("R1", int'(ofs), 0);
      chk("R1", int'(dmode), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", int'(ofs), 0);
      chk("R1", int'(dmode), 0);

      for (int s = 0; s < 4; s++) begin
         sel = 2'(s); en = 1'b1;
         do_reset();
         lo_seen = 0; hi_seen = 0;
         tick();
         chk("R6", int'(ofs), -slope_of(s));
         prev_ofs = int'(ofs);
         run(4 * N - 1, (s < 2) ? "R4" : "R5");
         chk("R2", lo_seen, -depth_of(s));
         chk("R2", hi_seen, (s < 2) ? depth_of(s) : 0);
      end

      sel = 2'd0; en = 1'b1;
      do_reset();
      run(3, "R4");
      en = 1'b0;
      run(N, "R7");
      for (int k = 0; k < 12; k++) begin
         sel = 2'(k);
         run(1, "R3");
         chk("R3", int'(ofs), 0);
      end
      en = 1'b1; sel = 2'd3;
      run(1, "R6");
      chk("R6", int'(ofs), -slope_of(3));
      run(2 * N, "R5");

      sel = 2'd0; en = 1'b1;
      do_reset();
      run(3, "R4");
      sel = 2'd1;
      run(3 * N, "R7");
      sel = 2'd2;
      run(3 * N, "R7");

      lfsr = 32'h1d3;
      for (int k = 0; k < 150; k++) begin
         lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
         sel = 2'(lfsr >> 8);
         en = ((lfsr >> 12) & 7) != 0;
         run(1 + ((lfsr >> 16) % 7), "R7");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule